// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, frame by frame, whether an incoming Ethernet frame should be kept. The destination address arrives one byte per cycle on a byte interface. A start-of-frame marker travels with the first byte. While the bytes arrive, the block shifts them into an address register and folds them into a running CRC-32. That CRC gives a 6-bit index into one of two 64-entry hash tables, one for unicast and one for group addresses.

When the sixth byte has been taken in, the block applies four rules in order of precedence:

1. Promiscuous override.
2. Broadcast accept or reject.
3. Group hash lookup.
4. Unicast exact match, falling back to the unicast hash.

It then presents a registered accept bit with a valid strobe. A reject also raises a one-cycle flush request, so the receive FIFO can discard the frame on its own. A separate flag reports what the normal filter alone would have decided, which is useful when promiscuous mode accepts everything.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: A frame begins on a cycle with `sofIn` and `byteValid` both high; that byte is destination byte 0. Bytes 1 to 5 are the next cycles with `byteValid` high. `decValid` stays low in the cycle after byte 5 is sampled and rises after the following clock edge.
- R2: A destination of all ones (broadcast) is accepted when `bcastReject` is 0 and rejected when it is 1, whatever the hash tables hold.
- R3: A destination that is not group is accepted when it equals `ownAddr`. Byte k of the frame is compared with `ownAddr[8k+7:8k]`.
- R4: A destination that is not group and misses the exact match is accepted if and only if `uniHashTbl[idx]` is 1; the group table has no effect on it. `idx` is computed as follows. Start a 32-bit CRC at all ones. For each of the 48 address bits, byte 0 first and bit 0 of each byte first, take feedback = crc[31] XOR bit, shift the CRC left by one, and XOR in 0x04C11DB7 when the feedback is 1. `idx` is CRC bits [31:26] after the 48th bit, with no final inversion.
- R5: A destination whose byte 0 has bit 0 set, other than broadcast, is a group address. It is accepted if and only if `grpHashTbl[idx]` is 1; the unicast table and `ownAddr` have no effect on it.
- R6: With `promiscEn` at 1 every frame is accepted.
- R7: `flushReq` is a single-cycle pulse, raised in the first cycle of `decValid` exactly when `accept` is 0. It is low at all other times.
- R8: After `decValid` rises, `decValid` and `accept` hold until the next start of frame, and further bytes without `sofIn` do not change them. A start of frame clears `decValid` and `accept` after its clock edge.
- R9: `normalPass` carries the normal-filter result for the frame (rules R2 to R5), so it shows a miss even while promiscuous mode accepts the frame.
- R10: If a start of frame arrives in the cycle in which a decision would be registered, the new frame wins. No decision and no flush appear for the old frame, and the new frame is decided normally.
- R11: While reset is held, `decValid`, `accept`, `flushReq` and `normalPass` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A destination byte is present |
| sofIn | input | 1 | Marks the first byte of a frame (qualified by byteValid) |
| byteData | input | 8 | Destination address byte |
| ownAddr | input | 48 | Programmed individual address, byte 0 in bits 7:0 |
| uniHashTbl | input | 64 | Unicast hash table |
| grpHashTbl | input | 64 | Group hash table |
| bcastReject | input | 1 | 1 rejects broadcast frames, 0 accepts them |
| promiscEn | input | 1 | Accept every frame |
| decValid | output | 1 | Decision valid, held until next start of frame |
| accept | output | 1 | 1 = keep frame, 0 = drop |
| flushReq | output | 1 | One-cycle request to drop the frame from the receive FIFO |
| normalPass | output | 1 | Result of the normal filter without the promiscuous override |

## Verification
Two events can fall on the same clock edge: registering the decision for a finished address, and a start-of-frame marker that clears the decision state. The bench provokes this by starting a new frame on the byte slot right after the sixth byte of a frame that would be rejected. It then checks that neither a valid strobe nor a flush pulse appears for the old frame, and that the new frame still gets its own correct decision on time.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             clear;
    logic             load;
    logic             decide;
    logic [IDX_W-1:0] idx;
  } filtStrobes_t;
endpackage

// File: rtl/addr_filt_ctrl.sv
module addr_filt_ctrl
  import addr_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         byteValid,
  input  logic         sofIn,
  output filtStrobes_t strobes
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);
  localparam logic [IDX_W-1:0] NUM_IDX  = IDX_W'(ADDR_BYTES);

  logic [IDX_W-1:0] byteCnt;
  logic             armed;
  logic             pendDecide;
  logic             newFrame;

  always_comb begin
    newFrame       = sofIn && byteValid;
    strobes.clear  = newFrame;
    strobes.load   = byteValid && (newFrame || (armed && byteCnt < NUM_IDX));
    strobes.decide = pendDecide && !newFrame;
    strobes.idx    = newFrame ? '0 : byteCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt    <= '0;
      armed      <= 1'b0;
      pendDecide <= 1'b0;
    end else if (newFrame) begin
      byteCnt    <= IDX_W'(1);
      armed      <= 1'b1;
      pendDecide <= 1'b0;
    end else begin
      pendDecide <= strobes.load && (byteCnt == LAST_IDX);
      if (strobes.load) byteCnt <= byteCnt + 1'b1;
    end
  end
endmodule

// File: rtl/addr_filt_datapath.sv
module addr_filt_datapath
  import addr_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  filtStrobes_t              strobes,
  input  logic [7:0]                byteData,
  input  logic [ADDR_BYTES*8-1:0]   ownAddr,
  input  logic [(1<<HASH_BITS)-1:0] uniHashTbl,
  input  logic [(1<<HASH_BITS)-1:0] grpHashTbl,
  input  logic                      bcastReject,
  input  logic                      promiscEn,
  output logic                      decValid,
  output logic                      accept,
  output logic                      flushReq,
  output logic                      normalPass
);
  localparam int          ADDR_W = ADDR_BYTES * 8;
  localparam logic [31:0] POLY   = 32'h04C1_1DB7;

  logic [ADDR_W-1:0]    addrReg;
  logic [31:0]          crcReg;
  logic [31:0]          crcSeed;
  logic [HASH_BITS-1:0] hashIdx;
  logic                 isBcast, isGroup, exactHit, filtPass, finalAcc;

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  always_comb begin
    crcSeed  = strobes.clear ? 32'hFFFF_FFFF : crcReg;
    hashIdx  = crcReg[31 -: HASH_BITS];
    isBcast  = &addrReg;
    isGroup  = addrReg[0];
    exactHit = (addrReg == ownAddr);
    if (isBcast)      filtPass = !bcastReject;
    else if (isGroup) filtPass = grpHashTbl[hashIdx];
    else              filtPass = exactHit || uniHashTbl[hashIdx];
    finalAcc = promiscEn || filtPass;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      crcReg  <= '1;
    end else if (strobes.load) begin
      addrReg[{strobes.idx, 3'b000} +: 8] <= byteData;
      crcReg <= crcByte(crcSeed, byteData);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid   <= 1'b0;
      accept     <= 1'b0;
      flushReq   <= 1'b0;
      normalPass <= 1'b0;
    end else if (strobes.clear) begin
      decValid   <= 1'b0;
      accept     <= 1'b0;
      flushReq   <= 1'b0;
      normalPass <= 1'b0;
    end else if (strobes.decide) begin
      decValid   <= 1'b1;
      accept     <= finalAcc;
      flushReq   <= !finalAcc;
      normalPass <= filtPass;
    end else begin
      flushReq   <= 1'b0;
    end
  end
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import addr_filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      byteValid,
  input  logic                      sofIn,
  input  logic [7:0]                byteData,
  input  logic [ADDR_BYTES*8-1:0]   ownAddr,
  input  logic [(1<<HASH_BITS)-1:0] uniHashTbl,
  input  logic [(1<<HASH_BITS)-1:0] grpHashTbl,
  input  logic                      bcastReject,
  input  logic                      promiscEn,
  output logic                      decValid,
  output logic                      accept,
  output logic                      flushReq,
  output logic                      normalPass
);
  filtStrobes_t strobes;

  addr_filt_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .sofIn(sofIn), .strobes(strobes)
  );

  addr_filt_datapath #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteData(byteData),
    .ownAddr(ownAddr), .uniHashTbl(uniHashTbl), .grpHashTbl(grpHashTbl),
    .bcastReject(bcastReject), .promiscEn(promiscEn),
    .decValid(decValid), .accept(accept), .flushReq(flushReq), .normalPass(normalPass)
  );
endmodule

// File: rtl/eth_rx_addr_filter_chk.sv
module eth_rx_addr_filter_chk (
  input logic clk,
  input logic rstN,
  input logic byteValid,
  input logic sofIn,
  input logic promiscEn,
  input logic decValid,
  input logic accept,
  input logic flushReq,
  input logic normalPass
);
  p_flush_reject_r7: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> (decValid && !accept));
  p_flush_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> !flushReq);
  p_reject_flushes_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(decValid) && !accept) |-> flushReq);
  p_promisc_accept_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(decValid) && promiscEn) |-> accept);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !(sofIn && byteValid)) |=> (decValid && $stable(accept)));
  p_sof_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sofIn && byteValid) |=> (!decValid && !flushReq));
  p_normal_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(decValid) && !promiscEn) |-> (accept == normalPass));
endmodule

bind eth_rx_addr_filter eth_rx_addr_filter_chk u_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .sofIn(sofIn), .promiscEn(promiscEn),
  .decValid(decValid), .accept(accept), .flushReq(flushReq), .normalPass(normalPass)
);

// File: tb/eth_rx_addr_filter_test.sv
`timescale 1ns/1ps
module eth_rx_addr_filter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic        sofIn = 1'b0;
  logic [7:0]  byteData = 8'h00;
  logic [47:0] ownAddr = 48'h5544_3322_1102;
  logic [63:0] uniHashTbl = '0;
  logic [63:0] grpHashTbl = '0;
  logic        bcastReject = 1'b0;
  logic        promiscEn = 1'b0;
  logic        decValid, accept, flushReq, normalPass;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  eth_rx_addr_filter uut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .sofIn(sofIn), .byteData(byteData),
    .ownAddr(ownAddr), .uniHashTbl(uniHashTbl), .grpHashTbl(grpHashTbl),
    .bcastReject(bcastReject), .promiscEn(promiscEn),
    .decValid(decValid), .accept(accept), .flushReq(flushReq), .normalPass(normalPass)
  );

  function automatic logic [5:0] hashOf(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      logic fb = c[31] ^ a[k];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return c[31:26];
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // drives 6 address bytes; returns at the negedge after the last byte was sampled
  task automatic sendAddr(input logic [47:0] a);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      byteValid = 1'b1;
      sofIn     = (k == 0);
      byteData  = a[8*k +: 8];
    end
    @(negedge clk);
    byteValid = 1'b0;
    sofIn     = 1'b0;
  endtask

  // full frame plus decision check one clock later
  task automatic judge(input string req, input logic [47:0] a, input logic expAcc, input logic expPass);
    sendAddr(a);
    check("R1", decValid, 1'b0, "decValid before decision edge");
    @(negedge clk);
    check("R1", decValid, 1'b1, "decValid after decision edge");
    check(req, accept, expAcc, "accept");
    check("R9", normalPass, expPass, "normalPass");
    check("R7", flushReq, !expAcc, "flushReq on decision");
    @(negedge clk);
    check("R7", flushReq, 1'b0, "flushReq one cycle later");
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R11", decValid, 1'b0, "decValid in reset");
    check("R11", accept, 1'b0, "accept in reset");
    check("R11", flushReq, 1'b0, "flushReq in reset");
    check("R11", normalPass, 1'b0, "normalPass in reset");
  endtask

  task automatic testBroadcast();
    grpHashTbl = '1;
    uniHashTbl = '1;
    bcastReject = 1'b0;
    judge("R2", '1, 1'b1, 1'b1);
    bcastReject = 1'b1;
    judge("R2", '1, 1'b0, 1'b0);
    grpHashTbl = '0;
    uniHashTbl = '0;
    bcastReject = 1'b0;
    judge("R2", '1, 1'b1, 1'b1);
  endtask

  task automatic testExact();
    judge("R3", ownAddr, 1'b1, 1'b1);
    judge("R3", ownAddr ^ 48'h0100_0000_0000, 1'b0, 1'b0);
  endtask

  task automatic testUniHash();
    logic [47:0] a = 48'h0A0B_0C0D_0E10;
    logic [5:0] ix = hashOf(a);
    uniHashTbl = '0;
    uniHashTbl[ix] = 1'b1;
    judge("R4", a, 1'b1, 1'b1);
    uniHashTbl = ~(64'd1 << ix);
    grpHashTbl = '1;
    judge("R4", a, 1'b0, 1'b0);
    uniHashTbl = '0;
    grpHashTbl = '0;
  endtask

  task automatic testGroup();
    logic [47:0] g = 48'h0000_5E00_0001;
    logic [5:0] ix = hashOf(g);
    grpHashTbl = '0;
    grpHashTbl[ix] = 1'b1;
    judge("R5", g, 1'b1, 1'b1);
    grpHashTbl = ~(64'd1 << ix);
    uniHashTbl = '1;
    ownAddr = g;
    judge("R5", g, 1'b0, 1'b0);
    ownAddr = 48'h5544_3322_1102;
    uniHashTbl = '0;
    grpHashTbl = '0;
  endtask

  task automatic testPromisc();
    promiscEn = 1'b1;
    judge("R6", 48'h1234_5678_9A00, 1'b1, 1'b0);
    bcastReject = 1'b1;
    judge("R6", '1, 1'b1, 1'b0);
    judge("R6", ownAddr, 1'b1, 1'b1);
    promiscEn = 1'b0;
    bcastReject = 1'b0;
  endtask

  task automatic testHold();
    judge("R8", ownAddr, 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      byteValid = 1'b1;
      byteData  = 8'h01;
    end
    @(negedge clk);
    byteValid = 1'b0;
    repeat (2) @(negedge clk);
    check("R8", decValid, 1'b1, "decValid held after extra bytes");
    check("R8", accept, 1'b1, "accept held after extra bytes");
    @(negedge clk);
    byteValid = 1'b1;
    sofIn = 1'b1;
    byteData = 8'hFF;
    @(negedge clk);
    byteValid = 1'b0;
    sofIn = 1'b0;
    check("R8", decValid, 1'b0, "decValid cleared by start of frame");
    check("R8", accept, 1'b0, "accept cleared by start of frame");
  endtask

  task automatic testCollide();
    logic [47:0] b = '1;
    bcastReject = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      byteValid = 1'b1;
      sofIn     = (k == 0);
      byteData  = (k == 0) ? 8'h40 : 8'h77;
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      byteValid = 1'b1;
      sofIn     = (k == 0);
      byteData  = b[8*k +: 8];
      if (k == 1) begin
        check("R10", decValid, 1'b0, "no decision for superseded frame");
        check("R10", flushReq, 1'b0, "no flush for superseded frame");
      end
    end
    @(negedge clk);
    byteValid = 1'b0;
    sofIn = 1'b0;
    check("R10", decValid, 1'b0, "new frame not yet decided");
    @(negedge clk);
    check("R10", decValid, 1'b1, "new frame decided");
    check("R10", accept, 1'b1, "new frame accept");
    check("R10", flushReq, 1'b0, "new frame no flush");
  endtask

  initial begin
    #(20 * 20000);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testBroadcast();
    testExact();
    testUniHash();
    testGroup();
    testPromisc();
    testHold();
    testCollide();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule